// File: doc/BRIEF.md
# Privilege-Checked Virtual Segment Decoder

This block sits between a processor's load/store address path and its translation lookaside buffer. It takes one 32-bit virtual address per request, together with the current privilege level and the error-level flag. It first sorts the address into one of five fixed regions. It then decides whether the running privilege level may touch that region.

Direct-mapped regions are translated inside the block, and their result appears in the same cycle as the request. Page-mapped regions are forwarded to the TLB through a valid-qualified request. The TLB's answer is held for one cycle and presented as the block's own result. Illegal accesses never reach the TLB and are answered at once with the bad-address code.

While a TLB lookup is outstanding, the block lowers `req_ready`. Requests offered while `req_ready` is low are dropped.

Top module: `vseg_decoder`

## Requirements
- R1: Without the error-level flag, an address whose top bit is 0 (the low half) is forwarded to the TLB at every privilege level. `tlb_req_valid` goes high, `tlb_req_vaddr` and `tlb_req_write` equal the request, and no result is given in that cycle.
- R2: With `req_erl`=1, a low-half address is answered in the same cycle without a TLB request. The result code is 0 (success), `rsp_paddr` equals the virtual address, and `rsp_perm`=2'b11.
- R3: In kernel mode (`req_mode`=2'b00), addresses 0x80000000 to 0x9FFFFFFF are answered in the same cycle. The result code is 0, the physical address is the virtual address minus 0x80000000, and `rsp_perm`=2'b11 (bit 0 is read, bit 1 is write).
- R4: In kernel mode, addresses 0xA0000000 to 0xBFFFFFFF are answered in the same cycle. The result code is 0, the physical address is the virtual address minus 0xA0000000, and `rsp_perm`=2'b11.
- R5: Addresses 0xC0000000 to 0xDFFFFFFF are forwarded to the TLB in kernel mode and in supervisor mode (2'b01). They are illegal in user mode.
- R6: Addresses 0xE0000000 and above are forwarded to the TLB in kernel mode only.
- R7: An illegal access is answered in the same cycle with no TLB request. The result code is 1 (bad address), `rsp_paddr`=0 and `rsp_perm`=0. Mode 2'b10 is user mode, and mode 2'b11 is treated as user. The error-level flag grants nothing in the upper half.
- R8: For a forwarded request, `rsp_valid` is high exactly one cycle after the cycle with `tlb_rsp_valid`. In that cycle the result code, physical address and permissions are the TLB's (codes: 0 success, 1 bad address, 2 no entry, 3 entry invalid, 4 write to clean page).
- R9: `req_ready` is low from the cycle after a TLB request up to and including the result cycle. A request offered while it is low causes neither a result nor a TLB request.
- R10: After reset, `req_ready`=1, `rsp_valid`=0 and `tlb_req_valid`=0.
- R11: A `tlb_rsp_valid` pulse while no lookup is outstanding produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VADDR_W | Virtual address |
| req_write | input | 1 | Access is a store |
| req_mode | input | 2 | Privilege: 00 kernel, 01 supervisor, 10 user |
| req_erl | input | 1 | Error-level flag |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 3 | Result code |
| rsp_paddr | output | PADDR_W | Physical address |
| rsp_perm | output | 2 | Bit 0 read, bit 1 write allowed |
| tlb_req_valid | output | 1 | Lookup request to the TLB |
| tlb_req_vaddr | output | VADDR_W | Address to look up |
| tlb_req_write | output | 1 | Lookup is for a store |
| tlb_rsp_valid | input | 1 | TLB answer valid |
| tlb_rsp_code | input | 3 | TLB result code |
| tlb_rsp_paddr | input | PADDR_W | TLB physical address |
| tlb_rsp_perm | input | 2 | TLB permissions |

## Verification
A wrong region or privilege decision shows in the same cycle as the request. It appears either as a result where a TLB request was due, or as a TLB request where a result was due, so every random request exposes it at once.

A stuck or skipped tracker state shows one cycle after the TLB answer. The result appears too early, too late or not at all, or `req_ready` fails to return. Random TLB latencies of one to four cycles, and requests pushed while busy, expose these faults.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
   localparam int CODE_W = 3;
   localparam int PERM_W = 2;

   localparam logic [CODE_W-1:0] RES_OK      = 3'd0;
   localparam logic [CODE_W-1:0] RES_BADADDR = 3'd1;
   localparam logic [CODE_W-1:0] RES_NOHIT   = 3'd2;
   localparam logic [CODE_W-1:0] RES_INVAL   = 3'd3;
   localparam logic [CODE_W-1:0] RES_CLEAN   = 3'd4;

   localparam logic [1:0] PRIV_KERN = 2'b00;
   localparam logic [1:0] PRIV_SUPV = 2'b01;
   localparam logic [1:0] PRIV_USER = 2'b10;

   localparam logic [PERM_W-1:0] PERM_RW   = 2'b11;
   localparam logic [PERM_W-1:0] PERM_NONE = 2'b00;

   typedef enum logic [1:0] {TRK_IDLE, TRK_WAIT, TRK_DONE} trk_state_e;
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
   import vseg_pkg::*;
#(
   parameter int VADDR_W = 32,
   parameter int PADDR_W = 32
) (
   input  logic [VADDR_W-1:0] vaddr,
   input  logic [1:0]         mode,
   input  logic               erl,
   output logic               legal,
   output logic               direct,
   output logic               mapped,
   output logic [PADDR_W-1:0] direct_paddr
);
   localparam int TOP    = VADDR_W - 1;
   localparam int LOW_W  = VADDR_W - 3;

   logic [2:0]         region;
   logic               is_kern;
   logic               is_supv;
   logic               low_half;
   logic [VADDR_W-1:0] src;

   assign region   = vaddr[TOP -: 3];
   assign low_half = ~vaddr[TOP];
   assign is_kern  = (mode == PRIV_KERN);
   assign is_supv  = (mode == PRIV_SUPV);

   always_comb begin
      unique casez (region)
         3'b0??:        legal = 1'b1;
         3'b100, 3'b101: legal = is_kern;
         3'b110:        legal = is_kern | is_supv;
         default:       legal = is_kern;
      endcase
   end

   assign direct = (low_half & erl) | (legal & (region[2:1] == 2'b10));
   assign mapped = legal & ~direct;

   assign src = low_half ? vaddr : {3'b000, vaddr[LOW_W-1:0]};

   generate
      if (PADDR_W >= VADDR_W) begin : g_widen
         assign direct_paddr = PADDR_W'(src);
      end else begin : g_narrow
         assign direct_paddr = src[PADDR_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/vseg_tracker.sv
module vseg_tracker
   import vseg_pkg::*;
#(
   parameter int PADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic               tlb_rsp_valid,
   input  logic [CODE_W-1:0]  tlb_rsp_code,
   input  logic [PADDR_W-1:0] tlb_rsp_paddr,
   input  logic [PERM_W-1:0]  tlb_rsp_perm,
   output logic               busy,
   output logic               done,
   output logic [CODE_W-1:0]  held_code,
   output logic [PADDR_W-1:0] held_paddr,
   output logic [PERM_W-1:0]  held_perm
);
   trk_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TRK_IDLE;
         held_code  <= RES_OK;
         held_paddr <= '0;
         held_perm  <= PERM_NONE;
      end else begin
         unique case (state_q)
            TRK_IDLE: if (launch) state_q <= TRK_WAIT;
            TRK_WAIT: if (tlb_rsp_valid) begin
               state_q    <= TRK_DONE;
               held_code  <= tlb_rsp_code;
               held_paddr <= tlb_rsp_paddr;
               held_perm  <= tlb_rsp_perm;
            end
            default:  state_q <= TRK_IDLE;
         endcase
      end
   end

   assign busy = (state_q != TRK_IDLE);
   assign done = (state_q == TRK_DONE);
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
   import vseg_pkg::*;
#(
   parameter int VADDR_W = 32,
   parameter int PADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VADDR_W-1:0] req_vaddr,
   input  logic               req_write,
   input  logic [1:0]         req_mode,
   input  logic               req_erl,
   output logic               rsp_valid,
   output logic [2:0]         rsp_code,
   output logic [PADDR_W-1:0] rsp_paddr,
   output logic [1:0]         rsp_perm,
   output logic               tlb_req_valid,
   output logic [VADDR_W-1:0] tlb_req_vaddr,
   output logic               tlb_req_write,
   input  logic               tlb_rsp_valid,
   input  logic [2:0]         tlb_rsp_code,
   input  logic [PADDR_W-1:0] tlb_rsp_paddr,
   input  logic [1:0]         tlb_rsp_perm
);
   generate
      if (VADDR_W != 32) begin : g_bad_vaddr
         $error("vseg_decoder: region boundaries assume a 32-bit virtual address");
      end
      if (PADDR_W < VADDR_W - 1) begin : g_bad_paddr
         $error("vseg_decoder: PADDR_W too narrow for the low-half identity map");
      end
   endgenerate

   logic               legal, direct, mapped;
   logic [PADDR_W-1:0] direct_paddr;
   logic               busy, done, accept;
   logic [CODE_W-1:0]  held_code;
   logic [PADDR_W-1:0] held_paddr;
   logic [PERM_W-1:0]  held_perm;

   vseg_classify #(.VADDR_W(VADDR_W), .PADDR_W(PADDR_W)) u_class (
      .vaddr(req_vaddr), .mode(req_mode), .erl(req_erl),
      .legal(legal), .direct(direct), .mapped(mapped),
      .direct_paddr(direct_paddr)
   );

   assign req_ready = ~busy;
   assign accept    = req_valid & req_ready;

   vseg_tracker #(.PADDR_W(PADDR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .launch(accept & mapped),
      .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_code(tlb_rsp_code),
      .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_rsp_perm(tlb_rsp_perm),
      .busy(busy), .done(done),
      .held_code(held_code), .held_paddr(held_paddr), .held_perm(held_perm)
   );

   assign tlb_req_valid = accept & mapped;
   assign tlb_req_vaddr = req_vaddr;
   assign tlb_req_write = req_write;

   always_comb begin
      rsp_valid = 1'b0;
      rsp_code  = RES_OK;
      rsp_paddr = '0;
      rsp_perm  = PERM_NONE;
      if (done) begin
         rsp_valid = 1'b1;
         rsp_code  = held_code;
         rsp_paddr = held_paddr;
         rsp_perm  = held_perm;
      end else if (accept && direct) begin
         rsp_valid = 1'b1;
         rsp_paddr = direct_paddr;
         rsp_perm  = PERM_RW;
      end else if (accept && !legal) begin
         rsp_valid = 1'b1;
         rsp_code  = RES_BADADDR;
      end
   end
endmodule

// File: rtl/vseg_decoder_chk.sv
module vseg_decoder_chk #(
   parameter int VADDR_W = 32,
   parameter int PADDR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [VADDR_W-1:0] req_vaddr,
   input logic [1:0]         req_mode,
   input logic               req_erl,
   input logic               rsp_valid,
   input logic [2:0]         rsp_code,
   input logic [PADDR_W-1:0] rsp_paddr,
   input logic               tlb_req_valid,
   input logic               tlb_rsp_valid,
   input logic [2:0]         tlb_rsp_code
);
   localparam logic [VADDR_W-1:0] HALF = {1'b1, {(VADDR_W-1){1'b0}}};
   logic acc;
   assign acc = req_valid && req_ready;

   AST_LOW_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_erl && !req_vaddr[VADDR_W-1] |-> tlb_req_valid && !rsp_valid); // R1
   AST_ERL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_erl && !req_vaddr[VADDR_W-1] |-> rsp_valid && rsp_code == 3'd0
      && rsp_paddr == PADDR_W'(req_vaddr)); // R2
   AST_KSEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_mode == 2'b00 && req_vaddr[VADDR_W-1 -: 3] == 3'b100
      |-> rsp_valid && rsp_paddr == PADDR_W'(req_vaddr - HALF)); // R3
   AST_USER_UPPER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_mode[1] && req_vaddr[VADDR_W-1]
      |-> rsp_valid && rsp_code == 3'd1 && !tlb_req_valid); // R7
   AST_TLB_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_rsp_valid && !req_ready && !rsp_valid
      |=> rsp_valid && rsp_code == $past(tlb_rsp_code)); // R8
   AST_BUSY_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid |=> !req_ready); // R9
   AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      !(tlb_req_valid && rsp_valid)); // R1
   AST_IDLE_TLB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_rsp_valid && req_ready |=> !rsp_valid || req_ready); // R11
endmodule

bind vseg_decoder vseg_decoder_chk #(.VADDR_W(VADDR_W), .PADDR_W(PADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vaddr(req_vaddr), .req_mode(req_mode), .req_erl(req_erl),
   .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
   .tlb_req_valid(tlb_req_valid), .tlb_rsp_valid(tlb_rsp_valid),
   .tlb_rsp_code(tlb_rsp_code)
);

// File: tb/vseg_decoder_test.sv
`timescale 1ns/1ps
module vseg_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_mode = 2'b00;
   logic        req_erl = 1'b0;
   logic        rsp_valid;
   logic [2:0]  rsp_code;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_perm;
   logic        tlb_req_valid;
   logic [31:0] tlb_req_vaddr;
   logic        tlb_req_write;
   logic        tlb_rsp_valid = 1'b0;
   logic [2:0]  tlb_rsp_code = '0;
   logic [31:0] tlb_rsp_paddr = '0;
   logic [1:0]  tlb_rsp_perm = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   vseg_decoder uut (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // 0 = illegal, 1 = direct, 2 = forwarded to TLB
   function automatic int exp_class(input logic [31:0] va, input logic [1:0] md,
                                    input logic erl);
      logic kern = (md == 2'b00);
      logic supv = (md == 2'b01);
      if (!va[31]) return erl ? 1 : 2;
      if (va[31:29] == 3'b100 || va[31:29] == 3'b101) return kern ? 1 : 0;
      if (va[31:29] == 3'b110) return (kern || supv) ? 2 : 0;
      return kern ? 2 : 0;
   endfunction

   function automatic logic [31:0] exp_paddr(input logic [31:0] va);
      if (!va[31]) return va;
      if (va[31:29] == 3'b100) return va - 32'h8000_0000;
      return va - 32'hA000_0000;
   endfunction

   function automatic string tag_of(input logic [31:0] va, input int cls);
      if (cls == 0) return "R7";
      if (!va[31]) return (cls == 1) ? "R2" : "R1";
      if (va[31:29] == 3'b100) return "R3";
      if (va[31:29] == 3'b101) return "R4";
      if (va[31:29] == 3'b110) return "R5";
      return "R6";
   endfunction

   task automatic one_req(input logic [31:0] va, input logic wr, input logic [1:0] md,
                          input logic erl, input int lat, input bit poke_busy);
      int cls = exp_class(va, md, erl);
      string tg = tag_of(va, cls);
      logic [2:0]  tc = 3'($urandom_range(0, 4));
      logic [31:0] tp = $urandom;
      logic [1:0]  tm = 2'($urandom_range(0, 3));
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_mode = md; req_erl = erl;
      #0.5;
      check(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
      if (cls == 2) begin
         check(tlb_req_valid && !rsp_valid && tlb_req_vaddr == va && tlb_req_write == wr,
               tg, {tlb_req_valid, rsp_valid, tlb_req_vaddr[29:0]}, {2'b10, va[29:0]});
         @(negedge clk);
         if (poke_busy) begin
            req_vaddr = 32'h8000_1000; req_mode = 2'b00; req_erl = 1'b0;
         end else req_valid = 1'b0;
         #0.5;
         check(!req_ready && !rsp_valid && !tlb_req_valid, "R9 busy ignores request",
               {req_ready, rsp_valid, tlb_req_valid}, 32'd0);
         for (int i = 1; i < lat; i++) @(negedge clk);
         tlb_rsp_valid = 1'b1; tlb_rsp_code = tc; tlb_rsp_paddr = tp; tlb_rsp_perm = tm;
         #0.5;
         check(!rsp_valid, "R8 no early result", 32'(rsp_valid), 32'd0);
         @(negedge clk);
         tlb_rsp_valid = 1'b0; tlb_rsp_paddr = '0; tlb_rsp_code = '0; tlb_rsp_perm = '0;
         #0.5;
         check(rsp_valid && rsp_code == tc && rsp_paddr == tp && rsp_perm == tm && !req_ready,
               "R8 TLB result", rsp_paddr ^ {rsp_valid, rsp_code, rsp_perm, 26'd0},
               tp ^ {1'b1, tc, tm, 26'd0});
         @(negedge clk);
         req_valid = 1'b0;
         #0.5;
         check(req_ready && !rsp_valid, "R9 ready after result",
               {req_ready, rsp_valid}, 32'd2);
      end else if (cls == 1) begin
         check(rsp_valid && !tlb_req_valid && rsp_code == 3'd0 && rsp_perm == 2'b11
               && rsp_paddr == exp_paddr(va), tg, rsp_paddr, exp_paddr(va));
         @(negedge clk); req_valid = 1'b0;
      end else begin
         check(rsp_valid && !tlb_req_valid && rsp_code == 3'd1 && rsp_perm == 2'b00
               && rsp_paddr == 32'd0, tg, {rsp_valid, tlb_req_valid, rsp_code, rsp_perm},
               {2'b10, 3'd1, 2'b00});
         @(negedge clk); req_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #1;
      check(req_ready && !rsp_valid && !tlb_req_valid, "R10 reset state",
            {req_ready, rsp_valid, tlb_req_valid}, 32'd4);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // directed corners
      one_req(32'h0000_0000, 0, 2'b10, 0, 1, 0); // R1 user low half
      one_req(32'h7FFF_FFFC, 1, 2'b00, 1, 1, 0); // R2 identity top of low half
      one_req(32'h8000_0000, 0, 2'b00, 0, 1, 0); // R3 base
      one_req(32'h9FFF_FFFF, 1, 2'b00, 1, 1, 0); // R3 top, erl no effect
      one_req(32'hA000_0000, 0, 2'b00, 0, 1, 0); // R4 base
      one_req(32'hBFFF_FFFF, 0, 2'b00, 0, 1, 0); // R4 top
      one_req(32'hC000_0000, 0, 2'b01, 0, 3, 1); // R5 supervisor
      one_req(32'hDFFF_FFFF, 0, 2'b10, 0, 1, 0); // R5 user illegal
      one_req(32'hE000_0000, 1, 2'b00, 0, 4, 1); // R6 kernel
      one_req(32'hFFFF_FFFF, 0, 2'b01, 0, 1, 0); // R6 supervisor illegal
      one_req(32'h8000_0000, 0, 2'b11, 1, 1, 0); // R7 mode 11 as user, erl grants nothing
      one_req(32'hA000_0010, 0, 2'b01, 0, 1, 0); // R7 supervisor direct region
      // R11: stray TLB answer while idle
      @(negedge clk);
      tlb_rsp_valid = 1'b1; tlb_rsp_code = 3'd2;
      @(negedge clk);
      tlb_rsp_valid = 1'b0;
      #0.5;
      check(!rsp_valid && req_ready, "R11 stray TLB answer", {rsp_valid, req_ready}, 32'd1);
      // constrained random
      for (int k = 0; k < 400; k++) begin
         logic [31:0] va = $urandom;
         logic [1:0]  md = 2'($urandom_range(0, 3));
         logic        er = ($urandom_range(0, 3) == 0);
         one_req(va, 1'($urandom), md, er, $urandom_range(1, 4), 1'($urandom));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule